// File: doc/BRIEF.md
# PCI Relocatable Address Resolver

This block turns a three-word PCI-style physical address into an absolute bus address and a target space. The request carries a control word (flags, space code, bus, device, function and register number), an upper address word and a lower address word. Requests marked fixed (non-relocatable) and configuration requests are resolved at once. A relocatable I/O or memory request is an offset from one of the device's base registers. The block finds that base in a small table of assigned entries and adds the two.

The table is presented on flat input buses together with an entry count. It is walked one entry per clock from entry 0 upward. Every entry visited must itself be a fixed entry with a nonzero register number. The first entry whose register number equals the request's ends the walk. The result appears with a one-cycle `done` pulse, together with an error code. A new request is taken only while the block is idle.

Top module: `pci_addr_resolver`

## Requirements
- R1: After synchronous reset `done`, `busy`, `out_addr`, `out_space` and `err_code` are all 0.
- R2: Control word fields: bit 31 fixed (non-relocatable), bits 25:24 space code, bits 7:0 register number. Space codes 0, 1, 2 and 3 resolve to `out_space` 0 (config), 1 (I/O), 2 (memory) and 2 (memory). `out_space` never takes the value 3.
- R3: A nonzero upper address word gives `err_code` 1 one cycle after `start`, and no table lookup is made.
- R4: A fixed request with upper word 0 gives `out_addr` equal to the lower word and `err_code` 0 one cycle after `start`. The table is not examined, so an invalid table has no effect.
- R5: A relocatable request with space code 0 gives the lower word with `out_space` 0 one cycle after `start`, without a lookup.
- R6: A relocatable request with space code 1 or 2 is resolved by the first table entry whose bits 7:0 equal the request's. The result is `out_addr` = request lower word + entry lower word (modulo 2^32) with `err_code` 0, and `done` comes k+2 cycles after `start` for a hit at entry k.
- R7: A visited entry with bit 31 clear or register number 0 ends the walk with `err_code` 2. Entries after a hit are not visited and cannot cause this error.
- R8: A matching entry whose space code (bits 25:24) differs from the request's ends the walk with `err_code` 3. Codes 2 and 3 count as different here.
- R9: When none of the first `tbl_count` entries match, `err_code` is 4 and `done` comes `tbl_count`+2 cycles after `start`. A count of 0 gives this after 2 cycles, and counts above the table depth act as the depth.
- R10: A relocatable request with space code 3 gives `err_code` 5 one cycle after `start`.
- R11: `busy` is high while the table is being walked. A `start` while busy is ignored, and `done` and `busy` are never high together.
- R12: Whenever `err_code` is nonzero at `done`, `out_addr` and `out_space` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| req_ctrl | input | 32 | Request control word |
| req_upper | input | 32 | Request upper address word |
| req_lower | input | 32 | Request lower address word |
| tbl_ctrl | input | 32*NENT | Control words of the assigned entries, entry i in bits 32i+31:32i |
| tbl_base | input | 32*NENT | Lower address words (bases) of the assigned entries |
| tbl_count | input | CNT_W | Number of valid table entries |
| busy | output | 1 | Table walk in progress |
| done | output | 1 | One-cycle result strobe |
| out_addr | output | 32 | Resolved bus address |
| out_space | output | 2 | 0 config, 1 I/O, 2 memory |
| err_code | output | 3 | 0 ok, 1 upper word set, 2 bad table, 3 type clash, 4 no base, 5 relocatable 64-bit |

## Verification
The assertions take for granted that the table buses and `tbl_count` stay steady while `busy` is high. The bound on the walk index and the consistency of the reported result both rest on that. The stimulus therefore loads each table and count while the block is idle and only then raises `start`. The one scenario that drives inputs mid-walk changes only the request and `start`, to show that a request arriving while busy is dropped.

// File: rtl/pci_res_pkg.sv
package pci_res_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SP_CONFIG = 2'd0,
        SP_IO     = 2'd1,
        SP_MEM    = 2'd2
    } space_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_WIDE_ADDR  = 3'd1,
        ERR_BAD_TABLE  = 3'd2,
        ERR_TYPE_CLASH = 3'd3,
        ERR_NO_BASE    = 3'd4,
        ERR_WIDE_RELOC = 3'd5
    } err_e;

    // Control word layout; field positions are decoded by software and tables.
    typedef struct packed {
        logic       fixed;
        logic       prefetch;
        logic       alias_en;
        logic [2:0] rsvd;
        logic [1:0] code;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [7:0] regno;
    } ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [WORD_W-1:0]  upper;
        logic [WORD_W-1:0]  lower;
    } pci_addr_t;

    typedef enum logic [1:0] {
        V_SKIP  = 2'd0,
        V_BAD   = 2'd1,
        V_CLASH = 2'd2,
        V_HIT   = 2'd3
    } verdict_e;

    typedef struct packed {
        logic              final_now;
        err_e              err;
        space_e            space;
        logic [WORD_W-1:0] addr;
    } result_t;

    function automatic space_e space_of(input logic [1:0] code);
        case (code)
            2'd0:    return SP_CONFIG;
            2'd1:    return SP_IO;
            default: return SP_MEM;
        endcase
    endfunction

    function automatic result_t fail_result(input err_e e);
        result_t r;
        r.final_now = 1'b1;
        r.err       = e;
        r.space     = SP_CONFIG;
        r.addr      = '0;
        return r;
    endfunction

endpackage

// File: rtl/pci_req_classify.sv
module pci_req_classify
    import pci_res_pkg::*;
(
    input  pci_addr_t req,
    output result_t   early
);
    always_comb begin
        early.final_now = 1'b1;
        early.err       = ERR_NONE;
        early.space     = space_of(req.ctrl.code);
        early.addr      = req.lower;
        if (req.upper != '0) begin
            early = fail_result(ERR_WIDE_ADDR);
        end else if (req.ctrl.fixed) begin
            early.final_now = 1'b1;
        end else if (req.ctrl.code == 2'd0) begin
            early.final_now = 1'b1;
        end else if (req.ctrl.code == 2'd3) begin
            early = fail_result(ERR_WIDE_RELOC);
        end else begin
            early.final_now = 1'b0;
        end
    end
endmodule

// File: rtl/pci_entry_check.sv
module pci_entry_check
    import pci_res_pkg::*;
(
    input  ctrl_t    req_ctrl,
    input  ctrl_t    ent_ctrl,
    output verdict_e verdict
);
    always_comb begin
        if (!ent_ctrl.fixed || ent_ctrl.regno == 8'd0)
            verdict = V_BAD;
        else if (ent_ctrl.regno != req_ctrl.regno)
            verdict = V_SKIP;
        else if (ent_ctrl.code != req_ctrl.code)
            verdict = V_CLASH;
        else
            verdict = V_HIT;
    end
endmodule

// File: rtl/pci_addr_resolver.sv
module pci_addr_resolver
    import pci_res_pkg::*;
#(
    parameter int NENT  = 8,
    parameter int CNT_W = $clog2(NENT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [31:0]            req_ctrl,
    input  logic [31:0]            req_upper,
    input  logic [31:0]            req_lower,
    input  logic [32*NENT-1:0]     tbl_ctrl,
    input  logic [32*NENT-1:0]     tbl_base,
    input  logic [CNT_W-1:0]       tbl_count,
    output logic                   busy,
    output logic                   done,
    output logic [31:0]            out_addr,
    output logic [1:0]             out_space,
    output logic [2:0]             err_code
);
    localparam int IDX_W = $clog2(NENT + 1);

    typedef enum logic {ST_IDLE, ST_SCAN} state_e;

    state_e            state_q;
    pci_addr_t         req_in, req_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  cnt_eff;
    ctrl_t             ent_ctrl_arr [NENT];
    logic [31:0]       ent_base_arr [NENT];
    ctrl_t             sel_ctrl;
    logic [31:0]       sel_base;
    result_t           early, walk;
    verdict_e          verdict;
    logic              walk_final;

    assign req_in = '{ctrl: ctrl_t'(req_ctrl), upper: req_upper, lower: req_lower};

    // Clamp the supplied count to the table depth.
    always_comb begin
        if (32'(tbl_count) > NENT) cnt_eff = IDX_W'(NENT);
        else                       cnt_eff = IDX_W'(tbl_count);
    end

    generate
        for (genvar g = 0; g < NENT; g++) begin : g_unpack
            assign ent_ctrl_arr[g] = ctrl_t'(tbl_ctrl[32*g +: 32]);
            assign ent_base_arr[g] = tbl_base[32*g +: 32];
        end
    endgenerate

    always_comb begin
        sel_ctrl = '0;
        sel_base = '0;
        for (int i = 0; i < NENT; i++) begin
            if (idx_q == IDX_W'(i)) begin
                sel_ctrl = ent_ctrl_arr[i];
                sel_base = ent_base_arr[i];
            end
        end
    end

    pci_req_classify u_classify (
        .req   (req_in),
        .early (early)
    );

    pci_entry_check u_check (
        .req_ctrl (req_q.ctrl),
        .ent_ctrl (sel_ctrl),
        .verdict  (verdict)
    );

    // Outcome of examining the current entry (or running off the table).
    always_comb begin
        walk_final = 1'b1;
        walk       = fail_result(ERR_NO_BASE);
        if (idx_q != cnt_eff) begin
            case (verdict)
                V_BAD:   walk = fail_result(ERR_BAD_TABLE);
                V_CLASH: walk = fail_result(ERR_TYPE_CLASH);
                V_HIT: begin
                    walk.err   = ERR_NONE;
                    walk.space = space_of(req_q.ctrl.code);
                    walk.addr  = req_q.lower + sel_base;
                end
                default: walk_final = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            req_q     <= '0;
            idx_q     <= '0;
            done      <= 1'b0;
            out_addr  <= '0;
            out_space <= '0;
            err_code  <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        idx_q <= '0;
                        if (early.final_now) begin
                            done      <= 1'b1;
                            out_addr  <= early.addr;
                            out_space <= early.space;
                            err_code  <= early.err;
                        end else begin
                            state_q <= ST_SCAN;
                        end
                    end
                end
                default: begin
                    if (walk_final) begin
                        state_q   <= ST_IDLE;
                        done      <= 1'b1;
                        out_addr  <= walk.addr;
                        out_space <= walk.space;
                        err_code  <= walk.err;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state_q == ST_SCAN);

    // Assertions
    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_idx_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx_q <= cnt_eff));

    assert_space_enc_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_space != 2'd3));

    assert_fixed_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 3'd0 && req_q.ctrl.fixed) |-> (out_addr == req_q.lower));

    assert_wide_reject_R3: assert property (@(posedge clk) disable iff (rst)
        (done && req_q.upper != '0) |-> (err_code == 3'd1));

    assert_err_clean_R12: assert property (@(posedge clk) disable iff (rst)
        (done && err_code != 3'd0) |-> (out_addr == '0 && out_space == 2'd0));

endmodule

// File: tb/pci_addr_resolver_bench.sv
module pci_addr_resolver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NENT = 8;
    localparam int CNT_W = $clog2(NENT + 1);

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [31:0] req_ctrl, req_upper, req_lower;
    logic [32*NENT-1:0] tbl_ctrl, tbl_base;
    logic [CNT_W-1:0] tbl_count;
    logic busy, done;
    logic [31:0] out_addr;
    logic [1:0] out_space;
    logic [2:0] err_code;

    logic [31:0] th [NENT];
    logic [31:0] tl [NENT];

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NENT; i++) begin
            tbl_ctrl[32*i +: 32] = th[i];
            tbl_base[32*i +: 32] = tl[i];
        end
    end

    pci_addr_resolver #(.NENT(NENT)) u_pci_addr_resolver (
        .clk(clk), .rst(rst), .start(start),
        .req_ctrl(req_ctrl), .req_upper(req_upper), .req_lower(req_lower),
        .tbl_ctrl(tbl_ctrl), .tbl_base(tbl_base), .tbl_count(tbl_count),
        .busy(busy), .done(done), .out_addr(out_addr),
        .out_space(out_space), .err_code(err_code)
    );

    function automatic logic [31:0] mk(input logic fx, input logic [1:0] code,
                                       input logic [7:0] regno);
        return {fx, 5'd0, code, 8'd0, 5'd3, 3'd1, regno};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < NENT; i++) begin
            th[i] = 32'd0;
            tl[i] = 32'd0;
        end
    endtask

    // Launch one request and measure cycles until done.
    task automatic run(input logic [31:0] c, input logic [31:0] u,
                       input logic [31:0] l, output int lat);
        @(negedge clk);
        req_ctrl = c; req_upper = u; req_lower = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic expect_res(input string tag, input int lat, input int exp_lat,
                              input logic [31:0] a, input logic [1:0] s, input logic [2:0] e);
        check({tag, " latency"}, lat, exp_lat);
        check({tag, " err"}, 32'(err_code), 32'(e));
        check({tag, " addr"}, out_addr, a);
        check({tag, " space"}, 32'(out_space), 32'(s));
    endtask

    task automatic t_reset();
        check("R1 done", 32'(done), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 addr", out_addr, 0);
        check("R1 space", 32'(out_space), 0);
        check("R1 err", 32'(err_code), 0);
    endtask

    task automatic t_wide_upper();
        int lat;
        run(mk(1, 2, 8'h10), 32'h1, 32'h1000, lat);
        expect_res("R3 upper set", lat, 1, 0, 0, 1);
    endtask

    task automatic t_fixed();
        int lat;
        clear_table();
        th[0] = mk(0, 1, 8'h00);
        tbl_count = 4'd3;
        run(mk(1, 1, 8'h14), 0, 32'hC000_0100, lat);
        expect_res("R4 fixed io", lat, 1, 32'hC000_0100, 1, 0);
        run(mk(1, 3, 8'h00), 0, 32'h8000_0000, lat);
        expect_res("R2 fixed code3 memory", lat, 1, 32'h8000_0000, 2, 0);
    endtask

    task automatic t_config();
        int lat;
        run(mk(0, 0, 8'h44), 0, 32'h0000_1234, lat);
        expect_res("R5 config", lat, 1, 32'h1234, 0, 0);
    endtask

    task automatic load_good();
        clear_table();
        th[0] = mk(1, 2, 8'h10); tl[0] = 32'h8000_1000;
        th[1] = mk(1, 3, 8'h18); tl[1] = 32'h9000_0000;
        th[2] = mk(1, 1, 8'h14); tl[2] = 32'h0000_4000;
        th[3] = mk(1, 2, 8'h20); tl[3] = 32'hFFFF_FF00;
        tbl_count = 4'd4;
    endtask

    task automatic t_hits();
        int lat;
        load_good();
        run(mk(0, 2, 8'h10), 0, 32'h20, lat);
        expect_res("R6 mem hit e0", lat, 2, 32'h8000_1020, 2, 0);
        run(mk(0, 1, 8'h14), 0, 32'h100, lat);
        expect_res("R6 io hit e2", lat, 4, 32'h4100, 1, 0);
        run(mk(0, 2, 8'h20), 0, 32'h200, lat);
        expect_res("R6 wrap hit e3", lat, 5, 32'h100, 2, 0);
    endtask

    task automatic t_bad_table();
        int lat;
        load_good();
        th[0] = mk(0, 2, 8'h10);
        run(mk(0, 2, 8'h10), 0, 32'h20, lat);
        expect_res("R7 relocatable entry", lat, 2, 0, 0, 2);
        load_good();
        th[1] = mk(1, 1, 8'h00);
        run(mk(0, 1, 8'h14), 0, 32'h4, lat);
        expect_res("R7 zero regno entry", lat, 3, 0, 0, 2);
        load_good();
        th[1] = mk(0, 1, 8'h00);
        run(mk(0, 2, 8'h10), 0, 32'h4, lat);
        expect_res("R7 bad after hit", lat, 2, 32'h8000_1004, 2, 0);
    endtask

    task automatic t_clash();
        int lat;
        load_good();
        run(mk(0, 2, 8'h18), 0, 32'h4, lat);
        expect_res("R8 code2 vs code3", lat, 3, 0, 0, 3);
    endtask

    task automatic t_missing();
        int lat;
        load_good();
        tbl_count = 4'd3;
        run(mk(0, 2, 8'h20), 0, 32'h4, lat);
        expect_res("R9 no match", lat, 5, 0, 0, 4);
        tbl_count = 4'd0;
        run(mk(0, 2, 8'h10), 0, 32'h4, lat);
        expect_res("R9 empty table", lat, 2, 0, 0, 4);
        clear_table();
        for (int i = 0; i < NENT; i++) th[i] = mk(1, 1, 8'h30 + 8'(i));
        tbl_count = 4'd12;
        run(mk(0, 1, 8'h7F), 0, 32'h4, lat);
        expect_res("R9 count clamp", lat, NENT + 2, 0, 0, 4);
    endtask

    task automatic t_wide_reloc();
        int lat;
        run(mk(0, 3, 8'h10), 0, 32'h4, lat);
        expect_res("R10 relocatable code3", lat, 1, 0, 0, 5);
    endtask

    task automatic t_busy_ignore();
        int lat, dones;
        load_good();
        @(negedge clk);
        req_ctrl = mk(0, 2, 8'h20); req_upper = 0; req_lower = 32'h10; start = 1'b1;
        @(negedge clk);
        check("R11 busy after start", 32'(busy), 1);
        req_ctrl = mk(1, 1, 8'h00); req_lower = 32'hDEAD_0000;
        lat = 1; dones = 0;
        while (lat < 12) begin
            @(negedge clk);
            lat++;
            if (done) begin
                dones++;
                check("R11 result of first request", out_addr, 32'h0000_0010 + 32'hFFFF_FF00);
                check("R11 latency", lat, 5);
                start = 1'b0;
            end
        end
        start = 1'b0;
        check("R11 single done", dones, 1);
        check("R11 idle", 32'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        req_ctrl = 0; req_upper = 0; req_lower = 0; tbl_count = 0;
        clear_table();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide_upper();
        t_fixed();
        t_config();
        t_hits();
        t_bad_table();
        t_clash();
        t_missing();
        t_wide_reloc();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule